// File: doc/BRIEF.md
# Protected Memory-to-Memory Processor Core

This core runs a fetch, decode and execute loop over one shared 256-byte memory. It has no general-purpose registers. Every instruction names up to two source cells and one destination cell, and all data is one byte wide. A mode bit separates system code from user code. While the core is in user mode, any fetch or data access to the low protected region is refused. The refused access is turned into a jump to a fixed entry address in system code.

Four kinds of event enter system mode: a memory violation, a user attempt to write the mode cell, a trap instruction, and the timer interrupt line. Each event copies a program counter into a saved-PC register, clears the mode bit and loads the entry address. A return instruction exchanges the PC with the saved PC and re-enters user mode in the same step. The bus is synchronous: read data returns one cycle after the address. The interrupt is acknowledged with a one-cycle pulse that lets the timer clear its request line.

Top module: `prot_core`

## Requirements
- R1: After reset the core is in system mode, the saved PC is 0, it is not halted, and the first bus address it issues is 0.
- R2: An instruction is four consecutive bytes: operator byte, source A, source B, destination. The low 6 bits of the operator byte select add (1), subtract (2), multiply (3) or divide (4). Results wrap modulo 256. Division by zero stores 0. The PC then advances by 4.
- R3: Bit 7 of the operator byte makes source A indirect and bit 6 makes source B indirect. An indirect source reads the named cell and uses its contents as the address of the operand.
- R4: In user mode, a fetch from an address below 100 loads the PC with 60, clears the mode bit and saves the fetch address as the saved PC.
- R5: In user mode, a source cell, an indirect target or a destination below 100 causes entry at 60, with the saved PC equal to the instruction's address and no memory write.
- R6: Cell 97 is the mode cell. A user-mode instruction that writes it enters at 64 and saves the instruction's address, leaving the cell unchanged. A system-mode write stores the value and sets the mode bit to bit 0 of it.
- R7: The interrupt input is examined when a fetch begins and takes precedence over the fetch protection check. It enters at 72, saves the address of the instruction not yet fetched, and raises the acknowledge output for exactly one cycle.
- R8: Opcode 8 (trap) enters at 68 and saves the trap's address plus 4. Opcode 9 (return) exchanges the PC with the saved PC and sets user mode.
- R9: Opcode 5 stores source A minus 1 into the destination. Opcode 6 jumps to the destination byte when source A is nonzero and otherwise advances by 4. Opcode 7 jumps to the destination byte unconditionally.
- R10: Any opcode other than 1 to 9 halts the core for good. While halted there are no writes and no interrupt entries.
- R11: Each entry raises the event pulse for one cycle. The vector output holds the last entry address until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Bus address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| irq_in | input | 1 | Timer interrupt request line |
| irq_ack | output | 1 | One-cycle acknowledge so the timer drops its request |
| exc_pulse | output | 1 | One-cycle pulse on every vectored entry |
| exc_vec | output | 8 | Entry address of the most recent event |
| saved_pc | output | 8 | Saved program counter |
| mode_user | output | 1 | 1 in user mode, 0 in system mode |
| halted | output | 1 | Set after an undefined opcode |

## Verification
The hardest situation to reach is the one where an interrupt request and a protected user fetch arrive at the same fetch. The bench builds it by letting system code set user mode and then run a user jump into the protected region. It raises the interrupt line when it sees the jump's last instruction byte on the bus. That places the request after the jump's own fetch and before the fetch at the low target. The expected entry is then 72 rather than 60, with the low target recorded as the saved PC.

// File: rtl/prot_core_pkg.sv
package prot_core_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_F1, ST_F2, ST_F3, ST_F4,
    ST_DEC, ST_RD, ST_LAT, ST_EXE, ST_HALT
  } core_state_t;

  localparam logic [5:0] OP_ADD  = 6'd1;
  localparam logic [5:0] OP_SUB  = 6'd2;
  localparam logic [5:0] OP_MUL  = 6'd3;
  localparam logic [5:0] OP_DIV  = 6'd4;
  localparam logic [5:0] OP_DEC  = 6'd5;
  localparam logic [5:0] OP_BNZ  = 6'd6;
  localparam logic [5:0] OP_JMP  = 6'd7;
  localparam logic [5:0] OP_TRAP = 6'd8;
  localparam logic [5:0] OP_RTE  = 6'd9;

  function automatic logic op_legal(input logic [5:0] opc);
    return (opc >= OP_ADD) && (opc <= OP_RTE);
  endfunction

  function automatic logic op_writes(input logic [5:0] opc);
    return (opc >= OP_ADD) && (opc <= OP_DEC);
  endfunction

  function automatic logic op_two_src(input logic [5:0] opc);
    return (opc >= OP_ADD) && (opc <= OP_DIV);
  endfunction

  function automatic logic op_reads(input logic [5:0] opc);
    return (opc >= OP_ADD) && (opc <= OP_BNZ);
  endfunction

  function automatic logic [7:0] calc(input logic [5:0] opc,
                                      input logic [7:0] x,
                                      input logic [7:0] y);
    logic [7:0] r;
    case (opc)
      OP_ADD:  r = x + y;
      OP_SUB:  r = x - y;
      OP_MUL:  r = x * y;
      OP_DIV:  r = (y == 8'd0) ? 8'd0 : x / y;
      OP_DEC:  r = x - 8'd1;
      default: r = 8'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/prot_core_alu.sv
module prot_core_alu
  import prot_core_pkg::*;
(
  input  logic [5:0] opc_i,
  input  logic [7:0] x_i,
  input  logic [7:0] y_i,
  output logic [7:0] res_o,
  output logic       nz_o
);
  assign res_o = calc(opc_i, x_i, y_i);
  assign nz_o  = (x_i != 8'd0);
endmodule

// File: rtl/prot_core_guard.sv
module prot_core_guard #(
  parameter int AW    = 8,
  parameter int LIMIT = 100
) (
  input  logic          user_i,
  input  logic [AW-1:0] addr_i,
  output logic          viol_o
);
  localparam logic [AW-1:0] LIM_V = AW'(LIMIT);
  assign viol_o = user_i && (addr_i < LIM_V);
endmodule

// File: rtl/prot_core.sv
module prot_core
  import prot_core_pkg::*;
#(
  parameter int AW        = 8,
  parameter int LIMIT     = 100,
  parameter int MODE_CELL = 97,
  parameter int VEC_MEM   = 60,
  parameter int VEC_MODE  = 64,
  parameter int VEC_TRAP  = 68,
  parameter int VEC_IRQ   = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          irq_in,
  output logic          irq_ack,
  output logic          exc_pulse,
  output logic [AW-1:0] exc_vec,
  output logic [AW-1:0] saved_pc,
  output logic          mode_user,
  output logic          halted
);
  localparam int NCHK = 3;
  localparam logic [AW-1:0] V_MEM  = AW'(VEC_MEM);
  localparam logic [AW-1:0] V_MODE = AW'(VEC_MODE);
  localparam logic [AW-1:0] V_TRAP = AW'(VEC_TRAP);
  localparam logic [AW-1:0] V_IRQ  = AW'(VEC_IRQ);
  localparam logic [AW-1:0] MCELL  = AW'(MODE_CELL);
  localparam logic [AW-1:0] LIM_V  = AW'(LIMIT);
  localparam logic [AW-1:0] STEP   = AW'(4);

  core_state_t   state;
  logic [AW-1:0] pc, epc, a_r, b_r, d_r, cur_addr;
  logic [7:0]    opb, v1, v2;
  logic          mode, k_r, ind_done;
  logic [5:0]    opc;
  logic [7:0]    alu_r;
  logic          alu_nz, cur_ind;

  logic                     take_exc, take_irq, rte_fire, chk_issue;
  logic [AW-1:0]            take_vec, take_epc;
  logic [NCHK-1:0][AW-1:0]  chk_addr;
  logic [NCHK-1:0]          viol;

  assign opc     = opb[5:0];
  assign cur_ind = k_r ? opb[6] : opb[7];

  // Protection checks: [0] fetch address, [1] operand address, [2] destination
  assign chk_addr[0] = pc;
  assign chk_addr[1] = cur_addr;
  assign chk_addr[2] = d_r;
  for (genvar g = 0; g < NCHK; g++) begin : g_guard
    prot_core_guard #(.AW(AW), .LIMIT(LIMIT)) u_guard (
      .user_i(mode), .addr_i(chk_addr[g]), .viol_o(viol[g])
    );
  end

  prot_core_alu u_alu (
    .opc_i(opc), .x_i(v1), .y_i(v2), .res_o(alu_r), .nz_o(alu_nz)
  );

  // Bus address per state
  always_comb begin
    case (state)
      ST_F1:   mem_addr = pc + AW'(1);
      ST_F2:   mem_addr = pc + AW'(2);
      ST_F3:   mem_addr = pc + AW'(3);
      ST_RD:   mem_addr = cur_addr;
      ST_EXE:  mem_addr = d_r;
      default: mem_addr = pc;
    endcase
  end

  assign mem_we    = (state == ST_EXE) && op_writes(opc) && !viol[2];
  assign mem_wdata = alu_r;
  assign chk_issue = ((state == ST_FETCH) && !irq_in && !viol[0]) ||
                     ((state == ST_RD) && !viol[1]);
  assign rte_fire  = (state == ST_DEC) && (opc == OP_RTE);

  // Event selection: interrupt outranks the fetch check
  always_comb begin
    take_exc = 1'b0;
    take_irq = 1'b0;
    take_vec = '0;
    take_epc = pc;
    case (state)
      ST_FETCH: begin
        if (irq_in) begin
          take_exc = 1'b1; take_irq = 1'b1; take_vec = V_IRQ;
        end else if (viol[0]) begin
          take_exc = 1'b1; take_vec = V_MEM;
        end
      end
      ST_DEC: begin
        if (opc == OP_TRAP) begin
          take_exc = 1'b1; take_vec = V_TRAP; take_epc = pc + STEP;
        end else if (op_writes(opc) && mode && (d_r == MCELL)) begin
          take_exc = 1'b1; take_vec = V_MODE;
        end
      end
      ST_RD: begin
        if (viol[1]) begin
          take_exc = 1'b1; take_vec = V_MEM;
        end
      end
      ST_EXE: begin
        if (op_writes(opc) && viol[2]) begin
          take_exc = 1'b1; take_vec = V_MEM;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      pc        <= '0;
      epc       <= '0;
      mode      <= 1'b0;
      opb       <= '0;
      a_r       <= '0;
      b_r       <= '0;
      d_r       <= '0;
      cur_addr  <= '0;
      v1        <= '0;
      v2        <= '0;
      k_r       <= 1'b0;
      ind_done  <= 1'b0;
      exc_pulse <= 1'b0;
      exc_vec   <= '0;
      irq_ack   <= 1'b0;
    end else begin
      exc_pulse <= 1'b0;
      irq_ack   <= 1'b0;
      if (take_exc) begin
        epc       <= take_epc;
        pc        <= take_vec;
        mode      <= 1'b0;
        exc_pulse <= 1'b1;
        exc_vec   <= take_vec;
        irq_ack   <= take_irq;
        state     <= ST_FETCH;
      end else begin
        case (state)
          ST_FETCH: state <= ST_F1;
          ST_F1: begin opb <= mem_rdata; state <= ST_F2; end
          ST_F2: begin a_r <= mem_rdata; state <= ST_F3; end
          ST_F3: begin b_r <= mem_rdata; state <= ST_F4; end
          ST_F4: begin d_r <= mem_rdata; state <= ST_DEC; end
          ST_DEC: begin
            if (!op_legal(opc)) begin
              state <= ST_HALT;
            end else if (opc == OP_JMP) begin
              pc <= d_r; state <= ST_FETCH;
            end else if (opc == OP_RTE) begin
              pc <= epc; epc <= pc; mode <= 1'b1; state <= ST_FETCH;
            end else if (op_reads(opc)) begin
              k_r <= 1'b0; ind_done <= 1'b0; cur_addr <= a_r; state <= ST_RD;
            end
          end
          ST_RD: state <= ST_LAT;
          ST_LAT: begin
            if (cur_ind && !ind_done) begin
              cur_addr <= mem_rdata; ind_done <= 1'b1; state <= ST_RD;
            end else begin
              if (!k_r) v1 <= mem_rdata;
              else      v2 <= mem_rdata;
              if (!k_r && op_two_src(opc)) begin
                k_r <= 1'b1; ind_done <= 1'b0; cur_addr <= b_r; state <= ST_RD;
              end else begin
                state <= ST_EXE;
              end
            end
          end
          ST_EXE: begin
            if (opc == OP_BNZ) begin
              pc <= alu_nz ? d_r : pc + STEP;
            end else begin
              pc <= pc + STEP;
              if (d_r == MCELL) mode <= alu_r[0];
            end
            state <= ST_FETCH;
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end

  assign saved_pc  = epc;
  assign mode_user = mode;
  assign halted    = (state == ST_HALT);

  AST_USER_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && chk_issue) |-> (mem_addr >= LIM_V)); // R4
  AST_USER_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && mem_we) |-> (mem_addr >= LIM_V)); // R5
  AST_MODE_CELL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && mem_we) |-> (mem_addr != MCELL)); // R6
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (exc_pulse && exc_vec == V_IRQ)); // R7
  AST_RTE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    rte_fire |=> (mode_user && pc == $past(epc) && saved_pc == $past(pc))); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && !exc_pulse)); // R10
  AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> (!mode_user && pc == exc_vec)); // R11
endmodule

// File: tb/prot_core_bench.sv
`timescale 1ns/1ps
module prot_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, exc_vec, saved_pc;
  logic       mem_we, irq_in, irq_ack, exc_pulse, mode_user, halted;
  logic [7:0] mem [0:255];

  int n_chk = 0, n_bad = 0;
  int ack_cnt = 0, pulse_cnt = 0, we_cnt = 0, user_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prot_core u_prot_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_in(irq_in),
    .irq_ack(irq_ack), .exc_pulse(exc_pulse), .exc_vec(exc_vec),
    .saved_pc(saved_pc), .mode_user(mode_user), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_ack)   ack_cnt++;
      if (exc_pulse) pulse_cnt++;
      if (mem_we)    we_cnt++;
      if (mode_user) user_seen++;
    end
  end

  function automatic int ref_op(input int o, input int x, input int y);
    case (o)
      1: return (x + y) % 256;
      2: return (x - y + 256) % 256;
      3: return (x * y) % 256;
      4: return (y == 0) ? 0 : x / y;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int at, input int o, input int x, input int y, input int z);
    mem[at] = 8'(o); mem[at+1] = 8'(x); mem[at+2] = 8'(y); mem[at+3] = 8'(z);
  endtask

  task automatic begin_test();
    rst_n = 1'b0;
    irq_in = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_core();
    ack_cnt = 0; pulse_cnt = 0; we_cnt = 0; user_seen = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
  endtask

  // System code jumps to 100, sets user mode there; user code starts at 104
  task automatic user_prologue();
    mem[250] = 8'd1; mem[251] = 8'd0;
    put(0, 7, 0, 0, 100);
    put(100, 1, 250, 251, 97);
  endtask

  task automatic t_reset();
    begin_test();
    put(0, 12, 0, 0, 0);
    release_core();
    chk("R1 first address", mem_addr, 0);
    chk("R1 mode", mode_user, 0);
    chk("R1 saved pc", saved_pc, 0);
    chk("R1 halted", halted, 0);
    chk("R1 pulse", exc_pulse, 0);
  endtask

  task automatic t_arith();
    begin_test();
    mem[150] = 8'd200; mem[151] = 8'd100; mem[152] = 8'd0;
    put(0, 1, 150, 151, 160);
    put(4, 2, 150, 151, 161);
    put(8, 3, 150, 151, 162);
    put(12, 4, 150, 151, 163);
    put(16, 4, 150, 152, 164);
    put(20, 2, 151, 150, 165);
    release_core();
    run_to_halt();
    chk("R2 add wrap", mem[160], ref_op(1, 200, 100));
    chk("R2 sub", mem[161], ref_op(2, 200, 100));
    chk("R2 mul wrap", mem[162], ref_op(3, 200, 100));
    chk("R2 div", mem[163], ref_op(4, 200, 100));
    chk("R2 div by zero", mem[164], 0);
    chk("R2 sub wrap", mem[165], ref_op(2, 100, 200));
    chk("R2 no event", pulse_cnt, 0);
  endtask

  task automatic t_indirect();
    begin_test();
    mem[150] = 8'd200; mem[151] = 8'd100; mem[170] = 8'd150; mem[171] = 8'd151;
    put(0, 8'h81, 170, 151, 160);
    put(4, 8'h42, 150, 171, 161);
    put(8, 8'hC3, 170, 171, 162);
    release_core();
    run_to_halt();
    chk("R3 indirect A", mem[160], ref_op(1, 200, 100));
    chk("R3 indirect B", mem[161], ref_op(2, 200, 100));
    chk("R3 both indirect", mem[162], ref_op(3, 200, 100));
  endtask

  task automatic t_loop();
    begin_test();
    mem[180] = 8'd5; mem[181] = 8'd0; mem[182] = 8'd3;
    put(0, 6, 180, 0, 12);
    put(4, 7, 0, 0, 28);
    put(12, 1, 181, 182, 181);
    put(16, 5, 180, 0, 180);
    put(20, 7, 0, 0, 0);
    release_core();
    run_to_halt();
    chk("R9 loop sum", mem[181], 15);
    chk("R9 counter", mem[180], 0);
    chk("R9 halted at end", halted, 1);
  endtask

  task automatic t_fetch_viol();
    begin_test();
    user_prologue();
    put(104, 7, 0, 0, 40);
    release_core();
    run_to_halt();
    chk("R6 system mode write", mem[97], 1);
    chk("R6 user entered", int'(user_seen > 0), 1);
    chk("R4 vector", exc_vec, 60);
    chk("R4 saved pc", saved_pc, 40);
    chk("R4 mode", mode_user, 0);
    chk("R11 single pulse", pulse_cnt, 1);
  endtask

  task automatic t_operand_viol(input int sel);
    begin_test();
    user_prologue();
    mem[150] = 8'd7; mem[151] = 8'd9; mem[170] = 8'd30; mem[20] = 8'h5A;
    mem[160] = 8'h33;
    case (sel)
      0: put(104, 1, 50, 151, 160);
      1: put(104, 8'h81, 170, 151, 160);
      default: put(104, 1, 150, 151, 20);
    endcase
    release_core();
    run_to_halt();
    chk($sformatf("R5 vector case %0d", sel), exc_vec, 60);
    chk($sformatf("R5 saved pc case %0d", sel), saved_pc, 104);
    chk($sformatf("R5 no write low case %0d", sel), mem[20], 8'h5A);
    chk($sformatf("R5 no write dst case %0d", sel), mem[160], 8'h33);
  endtask

  task automatic t_mode_viol();
    begin_test();
    user_prologue();
    put(104, 1, 251, 251, 97);
    release_core();
    run_to_halt();
    chk("R6 vector", exc_vec, 64);
    chk("R6 saved pc", saved_pc, 104);
    chk("R6 cell kept", mem[97], 1);
    chk("R6 mode", mode_user, 0);
  endtask

  task automatic t_trap();
    begin_test();
    user_prologue();
    mem[150] = 8'd20; mem[151] = 8'd22;
    put(104, 8, 3, 0, 0);
    put(108, 1, 150, 151, 160);
    put(68, 1, 150, 151, 161);
    put(72, 9, 0, 0, 0);
    release_core();
    run_to_halt();
    chk("R8 handler ran", mem[161], 42);
    chk("R8 resumed after trap", mem[160], 42);
    chk("R8 last vector", exc_vec, 68);
    chk("R8 saved pc swapped", saved_pc, 72);
    chk("R8 user after return", mode_user, 1);
  endtask

  task automatic t_irq_priority();
    begin_test();
    user_prologue();
    put(104, 7, 0, 0, 40);
    release_core();
    for (int i = 0; i < 500 && mem_addr != 8'd107; i++) @(negedge clk);
    irq_in = 1'b1;
    for (int i = 0; i < 500 && !irq_ack; i++) @(negedge clk);
    irq_in = 1'b0;
    run_to_halt();
    chk("R7 vector beats fetch check", exc_vec, 72);
    chk("R7 saved pc", saved_pc, 40);
    chk("R7 ack pulses", ack_cnt, 1);
    chk("R7 mode", mode_user, 0);
  endtask

  task automatic t_halt();
    begin_test();
    put(0, 10, 150, 151, 160);
    release_core();
    run_to_halt();
    chk("R10 halted", halted, 1);
    irq_in = 1'b1;
    repeat (30) @(negedge clk);
    irq_in = 1'b0;
    chk("R10 still halted", halted, 1);
    chk("R10 no ack", ack_cnt, 0);
    chk("R10 no writes", we_cnt, 0);
    chk("R10 vector unchanged", exc_vec, 0);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_indirect();
    t_loop();
    t_fetch_viol();
    for (int s = 0; s < 3; s++) t_operand_viol(s);
    t_mode_viol();
    t_trap();
    t_irq_priority();
    t_halt();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule